// File: doc/BRIEF.md
# I2C Register-Bank Slave with Status Readback

This block is an I2C target that lets a host program a bank of control registers kept elsewhere in the chip. A fast system clock oversamples the two bus wires. Each received write byte comes out as a single-cycle strobe that carries a register address and a data value. The control registers themselves live outside the block and are write-only from the bus. The only value a host can read is one status byte, taken from an input port.

A write transaction has three parts. It opens with the device address and a direction bit of 0. The next byte is a register pointer. Every byte after that is data: each one is stored at the pointer, and the pointer then steps by one.

A read transaction has no pointer phase. The block sends the status byte straight after the address acknowledge, and sends it again for as long as the host acknowledges.

A strap input selects one bit of the device address, so two of these blocks can share one bus. SDA is driven open-drain through a pull-down enable.

Top module: `i2c_regbank_slave`

## Requirements
- R1: While rst_n is low and after its release, sda_pull is 0 and wr_en is 0. The block stays idle until it sees a START condition.
- R2: The 7-bit device address is 1000100 when strap_i is 0 and 1000110 when strap_i is 1 (strap_i sets address bit 1). The eighth bit of the address byte selects the direction: 0 is write, 1 is read. A matching address is acknowledged.
- R3: If the address does not match, the block gives no acknowledge and produces no strobe. It ignores every later bit until the next START or STOP.
- R4: In a write, the first byte after the address is loaded as the register pointer. This byte produces no strobe.
- R5: Each data byte of a write is received MSB first. It produces exactly one single-cycle wr_en pulse, with wr_addr set to the current pointer and wr_data set to the byte.
- R6: After each stored data byte the pointer increases by one, and it wraps from 0xFF to 0x00.
- R7: The block pulls SDA low during the ninth SCL pulse after the matching address byte, after the pointer byte and after every data byte.
- R8: In a read, the block shifts status_i out MSB first, with no pointer phase. status_i is captured at the start of each byte. A master acknowledge (SDA low on the ninth pulse) starts another status byte. A master NACK makes the block release SDA and ignore the bus until the next START or STOP.
- R9: A repeated START discards a partly received byte without a strobe and restarts address reception. A STOP returns the block to idle, where SCL pulses without a START are ignored.
- R10: SCL and SDA each pass through a two-stage synchronizer. START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. sda_pull changes only while SCL is low, within a few system clocks of the SCL falling edge, which meets 400 kbit/s timing for any system clock above about 20 MHz.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock input |
| sda_i | input | 1 | Bus data input, read from the pad |
| sda_pull | output | 1 | When 1, the pad drives SDA low; when 0, SDA is released |
| strap_i | input | 1 | Device address select strap |
| status_i | input | 8 | Status byte returned by reads |
| wr_en | output | 1 | Register write strobe, one cycle wide |
| wr_addr | output | 8 | Register address for the strobe |
| wr_data | output | 8 | Register data for the strobe |

## Verification
Four properties are checked on every cycle:
- the outputs are quiet in reset;
- each write strobe lasts exactly one cycle and is followed by a pointer step of one;
- every strobe coincides with an acknowledge being driven;
- the SDA drive never changes while SCL is high.

Address matching for both strap settings, rejection of a wrong address, pointer load and wrap, status readback with acknowledge and NACK, abort on a repeated START, and idling after STOP all depend on whole bus transactions. Only the bench's directed scenarios show those, by comparing the logged strobes and the sampled SDA bits against expected values.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_DATA,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_SKIP
  } rb_state_t;
endpackage

// File: rtl/i2c_rb_sync.sv
module i2c_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic              scl_d, sda_d;
  logic              scl_s;

  // Synchronizer chains reset to the idle bus level (high).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  always_comb begin
    scl_s     = scl_q[STAGES-1];
    sda_s     = sda_q[STAGES-1];
    scl_rise  = scl_s & ~scl_d;
    scl_fall  = ~scl_s & scl_d;
    start_det = scl_s & scl_d & sda_d & ~sda_s;
    stop_det  = scl_s & scl_d & ~sda_d & sda_s;
  end
endmodule

// File: rtl/i2c_rb_ptr.sv
module i2c_rb_ptr #(
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PTR_W-1:0] load_val,
  input  logic             step,
  output logic [PTR_W-1:0] ptr
);
  logic [PTR_W-1:0] ptr_n;
  logic             ptr_en;

  always_comb begin
    ptr_en = load | step;
    ptr_n  = load ? load_val : ptr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else if (ptr_en) ptr <= ptr_n;
  end
endmodule

// File: rtl/i2c_rb_fsm.sv
module i2c_rb_fsm
  import i2c_rb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h44,
  parameter int         STRAP_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              strap_i,
  input  logic [BYTE_W-1:0] status_i,
  output logic              sda_pull,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_data,
  output logic              ptr_load,
  output logic [BYTE_W-1:0] ptr_value
);
  localparam logic [CNT_W-1:0] BITS = CNT_W'(BYTE_W);

  rb_state_t         state_q, state_n, next_q, next_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [BYTE_W-1:0] rx_q, rx_n, tx_q, tx_n, wd_q, wd_n;
  logic              pull_q, pull_n, wr_q, wr_n, ld_q, ld_n;
  logic [6:0]        dev_addr;

  always_comb begin
    dev_addr            = DEV_ADDR;
    dev_addr[STRAP_BIT] = strap_i;
  end

  always_comb begin
    state_n = state_q;
    next_n  = next_q;
    cnt_n   = cnt_q;
    rx_n    = rx_q;
    tx_n    = tx_q;
    wd_n    = wd_q;
    pull_n  = pull_q;
    wr_n    = 1'b0;
    ld_n    = 1'b0;
    if (start_det) begin
      state_n = ST_ADDR;
      cnt_n   = '0;
      pull_n  = 1'b0;
    end else if (stop_det) begin
      state_n = ST_IDLE;
      pull_n  = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_PTR, ST_DATA: begin
          if (scl_rise && (cnt_q < BITS)) begin
            rx_n  = {rx_q[BYTE_W-2:0], sda_s};
            cnt_n = cnt_q + 1'b1;
          end else if (scl_fall && (cnt_q == BITS)) begin
            if (state_q == ST_ADDR) begin
              if (rx_q[BYTE_W-1:1] == dev_addr) begin
                pull_n  = 1'b1;
                state_n = ST_ACK;
                next_n  = rx_q[0] ? ST_TX : ST_PTR;
              end else begin
                state_n = ST_SKIP;
              end
            end else if (state_q == ST_PTR) begin
              pull_n  = 1'b1;
              ld_n    = 1'b1;
              state_n = ST_ACK;
              next_n  = ST_DATA;
            end else begin
              pull_n  = 1'b1;
              wr_n    = 1'b1;
              wd_n    = rx_q;
              state_n = ST_ACK;
              next_n  = ST_DATA;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            cnt_n = '0;
            if (next_q == ST_TX) begin
              tx_n    = status_i;
              pull_n  = ~status_i[BYTE_W-1];
              state_n = ST_TX;
            end else begin
              pull_n  = 1'b0;
              state_n = next_q;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt_q == BITS - 1'b1) begin
              pull_n  = 1'b0;
              cnt_n   = '0;
              state_n = ST_MACK;
            end else begin
              tx_n   = {tx_q[BYTE_W-2:0], 1'b0};
              pull_n = ~tx_q[BYTE_W-2];
              cnt_n  = cnt_q + 1'b1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise && sda_s) begin
            state_n = ST_SKIP;
          end else if (scl_fall) begin
            tx_n    = status_i;
            pull_n  = ~status_i[BYTE_W-1];
            cnt_n   = '0;
            state_n = ST_TX;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      next_q  <= ST_IDLE;
      cnt_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      wd_q    <= '0;
      pull_q  <= 1'b0;
      wr_q    <= 1'b0;
      ld_q    <= 1'b0;
    end else begin
      state_q <= state_n;
      next_q  <= next_n;
      cnt_q   <= cnt_n;
      rx_q    <= rx_n;
      tx_q    <= tx_n;
      wd_q    <= wd_n;
      pull_q  <= pull_n;
      wr_q    <= wr_n;
      ld_q    <= ld_n;
    end
  end

  always_comb begin
    sda_pull  = pull_q;
    wr_en     = wr_q;
    wr_data   = wd_q;
    ptr_load  = ld_q;
    ptr_value = rx_q;
  end
endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave
  import i2c_rb_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR    = 7'h44,
  parameter int         STRAP_BIT   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull,
  input  logic              strap_i,
  input  logic [BYTE_W-1:0] status_i,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data
);
  logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              ptr_load;
  logic [BYTE_W-1:0] ptr_value;

  i2c_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_rb_fsm #(.DEV_ADDR(DEV_ADDR), .STRAP_BIT(STRAP_BIT)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .strap_i   (strap_i),
    .status_i  (status_i),
    .sda_pull  (sda_pull),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .ptr_load  (ptr_load),
    .ptr_value (ptr_value)
  );

  // The pointer steps on the strobe cycle, so wr_addr holds the old value
  // while wr_en is high.
  i2c_rb_ptr #(.PTR_W(BYTE_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ptr_load),
    .load_val (ptr_value),
    .step     (wr_en),
    .ptr      (wr_addr)
  );
endmodule

// File: rtl/i2c_rb_chk.sv
module i2c_rb_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_pull,
  input logic       wr_en,
  input logic [7:0] wr_addr
);
  // R1: outputs quiet while reset is held
  always_comb begin
    if (!rst_n) begin
      a_reset_quiet_r1: assert (!sda_pull && !wr_en);
    end
  end

  p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  p_ptr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (wr_addr == $past(wr_addr) + 8'd1));

  p_strobe_acked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> sda_pull);

  p_sda_steady_scl_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    scl_i |-> $stable(sda_pull));
endmodule

bind i2c_regbank_slave i2c_rb_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_i    (scl_i),
  .sda_pull (sda_pull),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr)
);

// File: tb/tb_i2c_regbank_slave.sv
module tb_i2c_regbank_slave;
  localparam int Q = 10;

  logic       clk, rst_n, m_scl, m_sda, strap, sda_line;
  logic       sda_pull, wr_en;
  logic [7:0] status, wr_addr, wr_data;
  int         n_run, n_fail, n_log;
  logic [7:0] log_a [0:15];
  logic [7:0] log_d [0:15];
  bit         done;

  assign sda_line = m_sda & ~sda_pull;

  i2c_regbank_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_pull(sda_pull), .strap_i(strap), .status_i(status),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      if (n_log < 16) begin
        log_a[n_log] = wr_addr;
        log_d[n_log] = wr_data;
      end
      n_log = n_log + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(Q);
    m_scl = 1'b1; wq(2*Q);
    m_sda = 1'b0; wq(2*Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b1; wq(2*Q);
    m_sda = 1'b1; wq(2*Q);
  endtask

  task automatic send_bit(input logic b);
    m_sda = b;    wq(Q);
    m_scl = 1'b1; wq(2*Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_sda = 1'b1; wq(Q);
    m_scl = 1'b1; wq(Q);
    acked = (sda_line == 1'b0);
    wq(Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic recv_byte(input logic ack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q);
      m_scl = 1'b1; wq(Q);
      b[i] = sda_line;
      wq(Q);
      m_scl = 1'b0;
    end
    wq(Q);
    send_bit(~ack);
  endtask

  task automatic t_reset();
    check("R1 sda_pull in reset", int'(sda_pull), 0);
    check("R1 wr_en in reset", int'(wr_en), 0);
    rst_n = 1'b1;
    wq(20);
    check("R1 sda_pull after reset", int'(sda_pull), 0);
    check("R1 no strobe after reset", n_log, 0);
  endtask

  task automatic t_write_burst();
    logic a;
    n_log = 0; strap = 1'b0;
    bus_start();
    send_byte(8'h88, a); check("R2 R7 addr 0x88 ack", int'(a), 1);
    send_byte(8'h10, a); check("R4 R7 pointer ack", int'(a), 1);
    check("R4 no strobe for pointer", n_log, 0);
    send_byte(8'hA5, a); check("R7 data ack 0", int'(a), 1);
    send_byte(8'h3C, a); check("R7 data ack 1", int'(a), 1);
    send_byte(8'h7E, a); check("R7 data ack 2", int'(a), 1);
    bus_stop();
    check("R5 strobe count", n_log, 3);
    check("R5 addr 0", int'(log_a[0]), 'h10); check("R5 data 0", int'(log_d[0]), 'hA5);
    check("R6 addr 1", int'(log_a[1]), 'h11); check("R5 data 1", int'(log_d[1]), 'h3C);
    check("R6 addr 2", int'(log_a[2]), 'h12); check("R5 data 2", int'(log_d[2]), 'h7E);
  endtask

  task automatic t_wrong_addr();
    logic a;
    n_log = 0; strap = 1'b0;
    bus_start();
    send_byte(8'h8C, a); check("R3 wrong addr nack", int'(a), 0);
    send_byte(8'h20, a); check("R3 ignored byte nack", int'(a), 0);
    send_byte(8'h55, a); check("R3 ignored data nack", int'(a), 0);
    bus_stop();
    check("R3 no strobe", n_log, 0);
  endtask

  task automatic t_strap_high();
    logic a;
    n_log = 0; strap = 1'b1;
    bus_start();
    send_byte(8'h88, a); check("R2 0x88 rejected with strap high", int'(a), 0);
    bus_stop();
    bus_start();
    send_byte(8'h8C, a); check("R2 0x8C ack with strap high", int'(a), 1);
    send_byte(8'h50, a);
    send_byte(8'h9A, a);
    bus_stop();
    check("R2 strap high strobe count", n_log, 1);
    check("R5 strap high addr", int'(log_a[0]), 'h50);
    check("R5 strap high data", int'(log_d[0]), 'h9A);
  endtask

  task automatic t_wrap();
    logic a;
    n_log = 0; strap = 1'b0;
    bus_start();
    send_byte(8'h88, a);
    send_byte(8'hFF, a);
    send_byte(8'h01, a);
    send_byte(8'h02, a);
    bus_stop();
    check("R6 wrap count", n_log, 2);
    check("R6 addr before wrap", int'(log_a[0]), 'hFF);
    check("R6 addr after wrap", int'(log_a[1]), 'h00);
  endtask

  task automatic t_read();
    logic a;
    logic [7:0] b;
    strap = 1'b1; status = 8'hB2; n_log = 0;
    bus_start();
    send_byte(8'h8D, a); check("R2 R8 read addr ack", int'(a), 1);
    recv_byte(1'b1, b); check("R8 first status byte", int'(b), 'hB2);
    recv_byte(1'b0, b); check("R8 repeated status byte", int'(b), 'hB2);
    recv_byte(1'b0, b); check("R8 released after NACK", int'(b), 'hFF);
    bus_stop();
    strap = 1'b0; status = 8'h4F;
    bus_start();
    send_byte(8'h89, a); check("R8 read addr strap low ack", int'(a), 1);
    recv_byte(1'b0, b); check("R8 status strap low", int'(b), 'h4F);
    bus_stop();
    check("R8 read makes no strobe", n_log, 0);
  endtask

  task automatic t_restart();
    logic a;
    n_log = 0; strap = 1'b0;
    bus_start();
    send_byte(8'h88, a);
    send_byte(8'h20, a);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    bus_start();
    send_byte(8'h88, a); check("R9 addr ack after repeated START", int'(a), 1);
    send_byte(8'h30, a);
    send_byte(8'h55, a);
    bus_stop();
    check("R9 partial byte dropped", n_log, 1);
    check("R9 new pointer used", int'(log_a[0]), 'h30);
    check("R9 new data", int'(log_d[0]), 'h55);
  endtask

  task automatic t_stop_idle();
    logic a;
    n_log = 0; strap = 1'b0;
    m_scl = 1'b0; wq(Q);
    send_byte(8'h88, a); check("R9 no ack without START", int'(a), 0);
    send_byte(8'h40, a);
    send_byte(8'h66, a);
    bus_stop();
    check("R9 no strobe without START", n_log, 0);
    check("R10 SDA released at idle", int'(sda_line), 1);
  endtask

  initial begin
    n_run = 0; n_fail = 0; n_log = 0; done = 1'b0;
    rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1; strap = 1'b0; status = 8'h00;
    wq(10);
    t_reset();
    t_write_burst();
    t_wrong_addr();
    t_strap_high();
    t_wrap();
    t_read();
    t_restart();
    t_stop_idle();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule